// File: doc/BRIEF.md
# Multichannel Memory-to-Memory Word Copy Engine

This block is a small DMA engine with a parameterized number of channels. Software programs each channel with a source address, a destination address, an address behaviour for each side (count up, count down or hold) and a byte count. It then launches one or more channels with a single write to a shared command word. The same command word, with its top bit set, cancels the selected channels.

Each active channel moves data one 32-bit word per beat over one shared memory port. A beat is a read request, the returned read data, and then a write request carrying that word. Channels that are waiting for the port are served one beat at a time in rotating order. The byte count register counts down live, so reading it while a segment runs returns the number of bytes still to move.

A channel signals the end of a segment with a one-cycle done pulse. A cancel produces the done pulse and an abort pulse together, one cycle after the command write. Loading the next segment is left to software.

Top module: `chdma_top`

## Requirements
- R1: After reset every channel register reads 0, no memory request is valid, and no done or abort pulse is raised.
- R2: The command word sits at byte offset 0x000. Channel c has a window at 0x100 + 0x40*c, holding source mode at +0x20, destination mode at +0x24, source address at +0x28, destination address at +0x2C and byte count at +0x30. A mode register stores only bits 5:4 and reads 0 in every other bit. The command word reads as 0.
- R3: The mode field (bits 5:4) selects 0 = address grows by 4 per beat, 1 = address shrinks by 4 per beat (modulo 2^32), 2 or 3 = address held. Source and destination sides follow their own fields.
- R4: Each beat reads one word at the current source address and then writes that word to the current destination address. The byte count drops by 4, or by the remaining count when fewer than 4 bytes are left. When the count reaches 0 the channel goes idle and pulses its done output for one cycle, after the edge that accepted the final write.
- R5: While a channel runs, its byte count register returns the bytes not yet written.
- R6: Writing the command word with bit 31 = 0 starts every channel whose bit (bit c for channel c) is 1. A start aimed at a channel that is already running is ignored.
- R7: Writes to a running channel's mode, address or count registers are ignored.
- R8: A start with a byte count of 0 raises done in the cycle after the command write, issues no memory request, and leaves the channel idle.
- R9: Writing the command word with bit 31 = 1 cancels the selected channels. A cancelled channel is idle in the cycle after the write and pulses both abort and done in that cycle, even if it was already idle. A beat already on the bus finishes its handshakes, but it changes no register of the cancelled channel.
- R10: When several channels are waiting, the port grants them in rotating order, one beat per grant.
- R11: A memory request that is valid but not yet accepted keeps its valid, write flag, address and write data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte address, used for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid, at least one cycle after the read is accepted |
| mem_rsp_rdata | input | 32 | Read data |
| done_evt | output | NUM_CH | One-cycle done pulse per channel |
| abort_evt | output | NUM_CH | One-cycle abort pulse per channel |

## Verification
A wrong address step or a wrong count update shows on the write side of the port at the very next beat, as a wrong write address or a word taken from the wrong source location. It also shows in the final address and count readback. A beat that is lost, or one too many, changes the number of writes seen before the done pulse. A cancel that is not honoured shows within one cycle, as a missing abort pulse or as a later change in the residue. An arbitration pointer that is stuck shows as two writes in a row from one channel while two channels are waiting.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

   typedef enum logic [1:0] {
      AM_INC  = 2'd0,
      AM_DEC  = 2'd1,
      AM_FIX  = 2'd2,
      AM_HOLD = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      ES_IDLE,
      ES_RD,
      ES_RWAIT,
      ES_WR
   } eng_state_e;

   localparam int WORD_BYTES   = 4;
   localparam int WIN_BASE_IDX = 4;   // first channel window at 0x100, 0x40 per window
   localparam int ABORT_BIT    = 31;

   localparam logic [5:0] RO_SMODE = 6'h20;
   localparam logic [5:0] RO_DMODE = 6'h24;
   localparam logic [5:0] RO_SADDR = 6'h28;
   localparam logic [5:0] RO_DADDR = 6'h2C;
   localparam logic [5:0] RO_SIZE  = 6'h30;

   function automatic logic [31:0] next_addr(input logic [31:0] a, input amode_e m);
      case (m)
         AM_INC:  return a + 32'd4;
         AM_DEC:  return a - 32'd4;
         default: return a;
      endcase
   endfunction

endpackage

// File: rtl/chdma_chan.sv
module chdma_chan
   import chdma_pkg::*;
#(
   parameter int SIZE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [5:0]        wr_ofs,
   input  logic [31:0]       wr_data,
   input  logic              start_hit,
   input  logic              abort_hit,
   input  logic              commit,
   output logic              busy,
   output logic [31:0]       src_addr,
   output logic [31:0]       dst_addr,
   output logic [SIZE_W-1:0] size_left,
   output amode_e            src_mode,
   output amode_e            dst_mode,
   output logic              done_evt,
   output logic              abort_evt
);

   localparam logic [SIZE_W-1:0] BEAT = SIZE_W'(WORD_BYTES);

   logic              last_beat;
   logic [SIZE_W-1:0] step;

   assign last_beat = (size_left <= BEAT);
   assign step      = last_beat ? size_left : BEAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         src_addr  <= '0;
         dst_addr  <= '0;
         size_left <= '0;
         src_mode  <= AM_INC;
         dst_mode  <= AM_INC;
         done_evt  <= 1'b0;
         abort_evt <= 1'b0;
      end else begin
         done_evt  <= 1'b0;
         abort_evt <= 1'b0;
         if (abort_hit) begin
            busy      <= 1'b0;
            done_evt  <= 1'b1;
            abort_evt <= 1'b1;
         end else if (start_hit && !busy) begin
            if (size_left == '0) done_evt <= 1'b1;
            else                 busy     <= 1'b1;
         end else if (commit && busy) begin
            src_addr  <= next_addr(src_addr, src_mode);
            dst_addr  <= next_addr(dst_addr, dst_mode);
            size_left <= size_left - step;
            if (last_beat) begin
               busy     <= 1'b0;
               done_evt <= 1'b1;
            end
         end
         if (wr_sel && !busy) begin
            case (wr_ofs)
               RO_SMODE: src_mode  <= amode_e'(wr_data[5:4]);
               RO_DMODE: dst_mode  <= amode_e'(wr_data[5:4]);
               RO_SADDR: src_addr  <= wr_data;
               RO_DADDR: dst_addr  <= wr_data;
               RO_SIZE:  size_left <= wr_data[SIZE_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   AST_ABORT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      abort_hit |=> (!busy && abort_evt && done_evt)); // R9

   AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && !busy && !abort_hit && size_left == '0) |=> (done_evt && !busy && !abort_evt)); // R8

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && busy && !abort_hit && !commit) |=> (busy && $stable(size_left) && !done_evt)); // R6

   AST_SIZE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && busy && !abort_hit) |=>
         (($past(size_left) - size_left) == BEAT) || (size_left == '0 && !busy && done_evt)); // R4

   AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && busy) |=> ($stable(src_mode) && $stable(dst_mode))); // R7

   AST_SRC_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && busy && !abort_hit && src_mode == AM_INC) |=> (src_addr == $past(src_addr) + 32'd4)); // R3

   AST_DST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && busy && !abort_hit && (dst_mode == AM_FIX || dst_mode == AM_HOLD)) |=> $stable(dst_addr)); // R3

endmodule

// File: rtl/chdma_rr_arb.sv
module chdma_rr_arb #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic              take,
   output logic [NUM_CH-1:0] grant
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] pick;
   logic             found;

   always_comb begin
      grant = '0;
      pick  = last_q;
      found = 1'b0;
      for (int k = 1; k <= NUM_CH; k++) begin
         int idx;
         idx = int'(last_q) + k;
         if (idx >= NUM_CH) idx = idx - NUM_CH;
         if (!found && take && req[idx]) begin
            grant[idx] = 1'b1;
            pick       = IDX_W'(idx);
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_q <= IDX_W'(NUM_CH - 1);
      else if (found) last_q <= pick;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R10

   AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0); // R10

endmodule

// File: rtl/chdma_beat_eng.sv
module chdma_beat_eng
   import chdma_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   output logic                   idle,
   input  logic [NUM_CH-1:0]      grant,
   input  logic [NUM_CH-1:0][31:0] src_vec,
   input  logic [NUM_CH-1:0][31:0] dst_vec,
   input  logic [NUM_CH-1:0]      abort_vec,
   output logic [NUM_CH-1:0]      commit_vec,
   output logic                   mem_req_valid,
   input  logic                   mem_req_ready,
   output logic                   mem_req_write,
   output logic [31:0]            mem_req_addr,
   output logic [31:0]            mem_req_wdata,
   input  logic                   mem_rsp_valid,
   input  logic [31:0]            mem_rsp_rdata
);

   eng_state_e        st_q;
   logic [NUM_CH-1:0] cur_q;
   logic [31:0]       sa_q, da_q, data_q;
   logic              killed_q;
   logic [31:0]       g_src, g_dst;
   logic              hit_abort;

   always_comb begin
      g_src = '0;
      g_dst = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (grant[i]) begin
            g_src = g_src | src_vec[i];
            g_dst = g_dst | dst_vec[i];
         end
      end
   end

   assign idle          = (st_q == ES_IDLE);
   assign hit_abort     = |(cur_q & abort_vec);
   assign mem_req_valid = (st_q == ES_RD) || (st_q == ES_WR);
   assign mem_req_write = (st_q == ES_WR);
   assign mem_req_addr  = mem_req_write ? da_q : sa_q;
   assign mem_req_wdata = data_q;
   assign commit_vec    = (st_q == ES_WR && mem_req_ready && !killed_q) ? (cur_q & ~abort_vec) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ES_IDLE;
         cur_q    <= '0;
         sa_q     <= '0;
         da_q     <= '0;
         data_q   <= '0;
         killed_q <= 1'b0;
      end else begin
         case (st_q)
            ES_IDLE: begin
               if (|grant) begin
                  cur_q    <= grant;
                  sa_q     <= g_src;
                  da_q     <= g_dst;
                  killed_q <= |(grant & abort_vec);
                  st_q     <= ES_RD;
               end
            end
            ES_RD: begin
               killed_q <= killed_q | hit_abort;
               if (mem_req_ready) st_q <= ES_RWAIT;
            end
            ES_RWAIT: begin
               killed_q <= killed_q | hit_abort;
               if (mem_rsp_valid) begin
                  data_q <= mem_rsp_rdata;
                  st_q   <= ES_WR;
               end
            end
            default: begin
               killed_q <= killed_q | hit_abort;
               if (mem_req_ready) st_q <= ES_IDLE;
            end
         endcase
      end
   end

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata))); // R11

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit_vec)); // R10

endmodule

// File: rtl/chdma_top.sv
module chdma_top
   import chdma_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CFG_AW = 12,
   parameter int SIZE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [31:0]       mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_rdata,
   output logic [NUM_CH-1:0] done_evt,
   output logic [NUM_CH-1:0] abort_evt
);

   localparam int WIN_W = CFG_AW - 6;

   if (NUM_CH < 1 || NUM_CH > 31) begin : g_bad_num_ch
      $error("chdma_top: NUM_CH must lie in 1..31");
   end
   if ((WIN_BASE_IDX + NUM_CH) * 64 > (1 << CFG_AW)) begin : g_bad_cfg_aw
      $error("chdma_top: CFG_AW too narrow for the channel windows");
   end
   if (SIZE_W < 3 || SIZE_W > 32) begin : g_bad_size_w
      $error("chdma_top: SIZE_W must lie in 3..32");
   end

   logic [WIN_W-1:0]              win;
   logic [5:0]                    ofs;
   logic                          cmd_wr;
   logic [NUM_CH-1:0]             start_vec, abort_vec, busy_vec, grant, commit_vec;
   logic [NUM_CH-1:0][31:0]       src_arr, dst_arr;
   logic [NUM_CH-1:0][SIZE_W-1:0] size_arr;
   amode_e                        smode_arr [NUM_CH];
   amode_e                        dmode_arr [NUM_CH];
   logic                          eng_idle;

   assign win       = cfg_addr[CFG_AW-1:6];
   assign ofs       = cfg_addr[5:0];
   assign cmd_wr    = cfg_we && (cfg_addr == '0);
   assign start_vec = (cmd_wr && !cfg_wdata[ABORT_BIT]) ? cfg_wdata[NUM_CH-1:0] : '0;
   assign abort_vec = (cmd_wr &&  cfg_wdata[ABORT_BIT]) ? cfg_wdata[NUM_CH-1:0] : '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [WIN_W-1:0] MY_WIN = WIN_W'(WIN_BASE_IDX + c);
      logic wr_sel;
      assign wr_sel = cfg_we && (win == MY_WIN);

      chdma_chan #(.SIZE_W(SIZE_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_sel    (wr_sel),
         .wr_ofs    (ofs),
         .wr_data   (cfg_wdata),
         .start_hit (start_vec[c]),
         .abort_hit (abort_vec[c]),
         .commit    (commit_vec[c]),
         .busy      (busy_vec[c]),
         .src_addr  (src_arr[c]),
         .dst_addr  (dst_arr[c]),
         .size_left (size_arr[c]),
         .src_mode  (smode_arr[c]),
         .dst_mode  (dmode_arr[c]),
         .done_evt  (done_evt[c]),
         .abort_evt (abort_evt[c])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (win == WIN_W'(WIN_BASE_IDX + c)) begin
            case (ofs)
               RO_SMODE: cfg_rdata = {26'd0, smode_arr[c], 4'd0};
               RO_DMODE: cfg_rdata = {26'd0, dmode_arr[c], 4'd0};
               RO_SADDR: cfg_rdata = src_arr[c];
               RO_DADDR: cfg_rdata = dst_arr[c];
               RO_SIZE:  cfg_rdata = 32'(size_arr[c]);
               default:  cfg_rdata = '0;
            endcase
         end
      end
   end

   chdma_rr_arb #(.NUM_CH(NUM_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (busy_vec),
      .take  (eng_idle),
      .grant (grant)
   );

   chdma_beat_eng #(.NUM_CH(NUM_CH)) u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .idle          (eng_idle),
      .grant         (grant),
      .src_vec       (src_arr),
      .dst_vec       (dst_arr),
      .abort_vec     (abort_vec),
      .commit_vec    (commit_vec),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_rdata (mem_rsp_rdata)
   );

   AST_CMD_START_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (|start_vec) |=> ((done_evt | busy_vec) & $past(start_vec)) == $past(start_vec)); // R6

endmodule

// File: tb/sim_chdma_top.sv
module sim_chdma_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic mem_req_valid, mem_req_write;
   logic mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic [NCH-1:0] done_evt, abort_evt;

   always #(CLK_PERIOD/2) clk = ~clk;

   chdma_top #(.NUM_CH(NCH), .CFG_AW(12), .SIZE_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata), .done_evt(done_evt), .abort_evt(abort_evt)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] mem [0:1023];
   logic [31:0] wlog_addr [0:511];
   logic [31:0] wlog_data [0:511];
   int wlog_n = 0;
   int req_seen = 0;
   int ready_pct = 100;
   logic hold_bus = 1'b0;

   function automatic logic [31:0] pat(input logic [9:0] idx);
      return ({22'd0, idx} * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   function automatic logic [31:0] step_ref(input logic [31:0] a, input logic [1:0] m);
      if (m == 2'd0) return a + 32'd4;
      if (m == 2'd1) return a - 32'd4;
      return a;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: decides ready at each falling edge, answers reads later
   initial begin
      int rsp_cnt;
      logic [31:0] rsp_data;
      rsp_cnt = 0;
      rsp_data = '0;
      for (int i = 0; i < 1024; i++) mem[i] = pat(10'(i));
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = rsp_data;
            end
         end
         if (mem_req_valid) req_seen++;
         mem_req_ready = hold_bus ? 1'b0 : (($urandom % 100) < 32'(ready_pct));
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               mem[mem_req_addr[11:2]] = mem_req_wdata;
               wlog_addr[wlog_n] = mem_req_addr;
               wlog_data[wlog_n] = mem_req_wdata;
               wlog_n++;
            end else begin
               rsp_data = mem[mem_req_addr[11:2]];
               rsp_cnt = 1 + int'($urandom % 3);
            end
         end
      end
   end

   task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [11:0] win(input int c, input logic [5:0] o);
      return 12'(32'h100 + 32'h40 * c) + {6'd0, o};
   endfunction

   task automatic wait_done(input int c, input string tag);
      int t;
      t = 0;
      while (!done_evt[c] && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(tag, 32'(done_evt[c]), 32'd1);
   endtask

   task automatic run_xfer(input int c, input logic [1:0] sm, input logic [1:0] dm,
                           input logic [31:0] sa, input logic [31:0] da, input logic [31:0] sz);
      logic [31:0] rd, s, d;
      int beats;
      beats = int'((sz + 32'd3) / 32'd4);
      cfg_write(win(c, 6'h20), {26'd0, sm, 4'd0});
      cfg_write(win(c, 6'h24), {26'd0, dm, 4'd0});
      cfg_write(win(c, 6'h28), sa);
      cfg_write(win(c, 6'h2C), da);
      cfg_write(win(c, 6'h30), sz);
      wlog_n = 0;
      req_seen = 0;
      cfg_write(12'h000, 32'd1 << c);
      if (sz == 0) begin
         chk("R8 zero count done next cycle", 32'(done_evt[c]), 32'd1);
         repeat (6) @(negedge clk);
         chk("R8 zero count no request", 32'(req_seen), 32'd0);
      end else begin
         wait_done(c, "R4 done pulse");
      end
      chk("R4 write beats", 32'(wlog_n), 32'(beats));
      s = sa;
      d = da;
      for (int k = 0; k < beats && k < wlog_n; k++) begin
         chk("R3 write address", wlog_addr[k], d);
         chk("R4 write data from source", wlog_data[k], pat(s[11:2]));
         s = step_ref(s, sm);
         d = step_ref(d, dm);
      end
      cfg_read(win(c, 6'h30), rd);
      chk("R4 final count", rd, 32'd0);
      cfg_read(win(c, 6'h28), rd);
      chk("R3 final source address", rd, s);
      cfg_read(win(c, 6'h2C), rd);
      chk("R3 final destination address", rd, d);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd, rd2, res;
      int wc;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cfg_read(win(0, 6'h30), rd);
      chk("R1 count after reset", rd, 32'd0);
      cfg_read(win(2, 6'h28), rd);
      chk("R1 source address after reset", rd, 32'd0);
      chk("R1 no request after reset", 32'(mem_req_valid), 32'd0);
      chk("R1 no pulses after reset", {28'd0, done_evt | abort_evt}, 32'd0);

      // R2: register map readback
      cfg_write(win(1, 6'h20), 32'hFFFF_FFFF);
      cfg_write(win(1, 6'h24), 32'h0000_0010);
      cfg_write(win(1, 6'h28), 32'h1234_5678);
      cfg_write(win(1, 6'h2C), 32'h8765_4320);
      cfg_write(win(1, 6'h30), 32'h0000_0055);
      cfg_read(win(1, 6'h20), rd);  chk("R2 source mode field only", rd, 32'h30);
      cfg_read(win(1, 6'h24), rd);  chk("R2 destination mode", rd, 32'h10);
      cfg_read(win(1, 6'h28), rd);  chk("R2 source address", rd, 32'h1234_5678);
      cfg_read(win(1, 6'h2C), rd);  chk("R2 destination address", rd, 32'h8765_4320);
      cfg_read(win(1, 6'h30), rd);  chk("R2 count", rd, 32'h55);
      cfg_read(win(0, 6'h30), rd);  chk("R2 other window untouched", rd, 32'd0);
      cfg_read(12'h000, rd);        chk("R2 command reads zero", rd, 32'd0);

      // R3 / R4 directed: decrementing source, held destination, partial tail
      ready_pct = 70;
      run_xfer(3, 2'd1, 2'd2, 32'h0000_0300, 32'h0000_0B00, 32'd10);
      // R8: zero count
      run_xfer(0, 2'd0, 2'd0, 32'h0000_0200, 32'h0000_0A00, 32'd0);

      // random segments on random channels and modes
      for (int it = 0; it < 14; it++) begin
         int c;
         logic [1:0] sm, dm;
         logic [31:0] sa, da, sz;
         c  = int'($urandom % NCH);
         sm = 2'($urandom % 4);
         dm = 2'($urandom % 4);
         sa = 32'h200 + (($urandom % 128) << 2);
         da = 32'hA00 + (($urandom % 128) << 2);
         sz = $urandom % 41;
         ready_pct = 40 + int'($urandom % 61);
         run_xfer(c, sm, dm, sa, da, sz);
      end

      // R5 / R6 / R7 / R9 on a long segment
      ready_pct = 100;
      cfg_write(win(2, 6'h20), 32'h00);
      cfg_write(win(2, 6'h24), 32'h00);
      cfg_write(win(2, 6'h28), 32'h200);
      cfg_write(win(2, 6'h2C), 32'hA00);
      cfg_write(win(2, 6'h30), 32'd400);
      wlog_n = 0;
      cfg_write(12'h000, 32'h4);
      repeat (20) @(negedge clk);
      @(posedge clk);
      #2;
      hold_bus = 1'b1;
      repeat (4) @(negedge clk);
      cfg_read(win(2, 6'h30), res);
      chk("R5 residue while running", res, 32'd400 - 32'd4 * 32'(wlog_n));
      cfg_write(win(2, 6'h30), 32'd8);
      cfg_read(win(2, 6'h30), rd);
      chk("R7 count write ignored while running", rd, res);
      cfg_write(win(2, 6'h20), 32'h20);
      cfg_read(win(2, 6'h20), rd);
      chk("R7 mode write ignored while running", rd, 32'h0);
      cfg_write(12'h000, 32'h4);
      chk("R6 restart ignored no done", 32'(done_evt[2]), 32'd0);
      cfg_read(win(2, 6'h30), rd);
      chk("R6 restart ignored count kept", rd, res);
      cfg_write(12'h000, 32'h8000_000C);
      chk("R9 abort pulse", {28'd0, abort_evt}, 32'h0000_000C);
      chk("R9 done with abort", {28'd0, done_evt}, 32'h0000_000C);
      hold_bus = 1'b0;
      repeat (20) @(negedge clk);
      wc = wlog_n;
      repeat (20) @(negedge clk);
      chk("R9 no writes after abort", 32'(wlog_n), 32'(wc));
      cfg_read(win(2, 6'h30), rd2);
      chk("R9 in-flight beat leaves count", rd2, res);
      // channel usable again after abort
      run_xfer(2, 2'd0, 2'd0, 32'h0000_0240, 32'h0000_0D00, 32'd8);

      // R10: two channels waiting alternate
      ready_pct = 100;
      cfg_write(win(0, 6'h20), 32'h00);
      cfg_write(win(0, 6'h24), 32'h00);
      cfg_write(win(0, 6'h28), 32'h200);
      cfg_write(win(0, 6'h2C), 32'hA00);
      cfg_write(win(0, 6'h30), 32'd16);
      cfg_write(win(1, 6'h20), 32'h00);
      cfg_write(win(1, 6'h24), 32'h00);
      cfg_write(win(1, 6'h28), 32'h300);
      cfg_write(win(1, 6'h2C), 32'hC00);
      cfg_write(win(1, 6'h30), 32'd16);
      wlog_n = 0;
      cfg_write(12'h000, 32'h3);
      repeat (80) @(negedge clk);
      chk("R10 total beats", 32'(wlog_n), 32'd8);
      for (int k = 0; k < 7; k++) begin
         chk("R10 rotation between channels",
             32'(wlog_addr[k][11:10] == wlog_addr[k+1][11:10]), 32'd0);
      end
      cfg_read(win(0, 6'h30), rd);
      chk("R10 channel 0 finished", rd, 32'd0);
      cfg_read(win(1, 6'h30), rd);
      chk("R10 channel 1 finished", rd, 32'd0);

      summary();
      $finish;
   end

   // R11 watched at the port by the bench as well
   initial begin
      logic pv;
      logic [31:0] pa;
      pv = 1'b0;
      pa = '0;
      forever begin
         @(negedge clk);
         if (rst_n && pv && !mem_req_valid) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 request dropped actual=0 expected=1");
         end
         if (rst_n && pv && mem_req_valid && mem_req_addr !== pa) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 address moved actual=%h expected=%h", mem_req_addr, pa);
         end
         pv = mem_req_valid && !mem_req_ready;
         pa = mem_req_addr;
      end
   end

endmodule